// File: doc/BRIEF.md
# Transactional Abort Sample Recorder

This block watches a core's transactional-execution status pulses: region begin, commit and abort, plus the region kind, which is either lock-elision or explicit. It keeps one programmable abort-event counter per slot. When a chosen counter wraps, or when a sample request arrived during the open region, the block waits for the region's abort to finish. It then offers one record on a valid/ready port. The record holds the eventing instruction address, the restart address of the outermost region, and a 64-bit abort-information word.

A sample request that arrives while a region is open does not wait for the region to end. The block raises an abort request toward the core and builds the record only once that abort has happened. The region cycle count covers the outermost region from begin to end inclusive. Counters and their event selections are written and read through a small register port.

Top module: `txab_sampler`

## Requirements
- R1: After reset `rec_valid` and `abort_req` are 0, and every register reads as zero.
- R2: Register map: even address 2*i is slot i's select (bits 7:0 event code, 15:8 unit mask, 16 enable), odd address 2*i+1 is slot i's count, address 2*NUM_CTR is status (bit 0 lost flag; any write clears it). An enabled slot counts one per region abort only for code C8h with mask 04h when the region is lock-elision (`tx_kind`=0), or code C9h with mask 04h when it is explicit (`tx_kind`=1); other selections and disabled slots do not count.
- R3: A counted abort that wraps a counter from all-ones to zero triggers a record. After that, the slot produces no record on a later wrap until its count register is rewritten.
- R4: A `sample_req` during an open region drives `abort_req` high from the next cycle until the region ends. A `sample_req` with no region open is ignored.
- R5: A triggered record appears on `rec_valid` in the cycle after the abort pulse, never before it.
- R6: `rec_info[31:0]` is the number of cycles from the outermost begin to the ending pulse inclusive, saturating at 2^CYC_W-1.
- R7: `rec_info[32]` is set for a lock-elision region and `rec_info[33]` for an explicit one. The kind is taken at the outermost begin.
- R8: `rec_info[39:34]` are `abort_cause[5:0]`, which are in order instruction-related, not instruction-related, retry may succeed, data conflict, write capacity, and read capacity. `rec_info[63:40]` are zero.
- R9: `rec_restart_ip` is `begin_next_ip` for a lock-elision region and `begin_fallback_ip` for an explicit one, sampled at the outermost begin. Nested begins change neither address nor kind.
- R10: `rec_eventing_ip` is `eventing_ip` as sampled with the abort pulse.
- R11: A record stays valid and unchanged until accepted with `rec_ready`. A trigger that arrives while a record is held is dropped and sets the lost flag.
- R12: A commit, even one with a sample pending, produces no record and drops the request. An abort with neither a pending sample nor a counter wrap produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Region begin pulse |
| tx_commit | input | 1 | Region commit pulse |
| tx_abort | input | 1 | Region abort pulse |
| tx_kind | input | 1 | Kind at begin: 0 lock-elision, 1 explicit |
| abort_cause | input | 6 | Cause flags valid with the abort pulse |
| eventing_ip | input | AW | Eventing instruction address valid with the abort pulse |
| begin_next_ip | input | AW | Address after the elided-lock acquire, valid with begin |
| begin_fallback_ip | input | AW | Fallback handler address, valid with begin |
| sample_req | input | 1 | A sample became pending |
| abort_req | output | 1 | Request to abort the open region |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | clog2(2*NUM_CTR+1) | Register address |
| reg_wdata | input | max(CTR_W,17) | Register write data |
| reg_rdata | output | max(CTR_W,17) | Register read data (combinational) |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Record accepted |
| rec_eventing_ip | output | AW | Record eventing address |
| rec_restart_ip | output | AW | Record restart address |
| rec_info | output | 64 | Record abort-information word |

## Verification
The bench runs a small build with 8-bit counters and a 5-bit cycle counter, so it can drive wraps and saturation directly. It sweeps region lengths across the saturation point and alternates kind and cause patterns with each length. That separates off-by-one counting, a missing saturation, kind swaps and cause bit misplacement. Counters are tried under matching, mismatched and disabled selections and through a full disarmed wrap, which separates counting from triggering. Held-record, commit-with-pending and request-outside-region cases separate the drop path from the capture path.

// File: rtl/txab_pkg.sv
`timescale 1ns/1ps
package txab_pkg;
    localparam logic [7:0] EV_ELIDE_ABORT = 8'hC8;
    localparam logic [7:0] EV_EXPL_ABORT  = 8'hC9;
    localparam logic [7:0] UMASK_ABORT    = 8'h04;
    localparam int         SEL_W          = 17;
    localparam int         CAUSE_W        = 6;

    typedef enum logic {KIND_ELIDE = 1'b0, KIND_EXPLICIT = 1'b1} tx_kind_e;

    function automatic int reg_w(int ctr_w);
        return (ctr_w > SEL_W) ? ctr_w : SEL_W;
    endfunction

    function automatic logic [63:0] pack_info(logic [31:0] cycles, tx_kind_e kind,
                                              logic [CAUSE_W-1:0] cause);
        return {24'h0, cause, kind == KIND_EXPLICIT, kind == KIND_ELIDE, cycles};
    endfunction
endpackage

// File: rtl/txab_region.sv
`timescale 1ns/1ps
module txab_region
    import txab_pkg::*;
#(
    parameter int AW      = 64,
    parameter int CYC_W   = 32,
    parameter int DEPTH_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_begin,
    input  logic             tx_commit,
    input  logic             tx_abort,
    input  tx_kind_e         tx_kind,
    input  logic [AW-1:0]    begin_next_ip,
    input  logic [AW-1:0]    begin_fallback_ip,
    input  logic             sample_req,
    output logic             open_o,
    output logic             abort_ev_o,
    output logic             pend_now_o,
    output logic             req_o,
    output tx_kind_e         kind_o,
    output logic [AW-1:0]    restart_o,
    output logic [CYC_W-1:0] end_cycles_o
);
    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic [CYC_W-1:0]   cyc;
        tx_kind_e           kind;
        logic [AW-1:0]      restart;
        logic               pend;
    } region_t;

    region_t s_d, s_q;
    logic    open, ending;
    logic [CYC_W-1:0] cyc_inc;

    always_comb begin
        s_d      = s_q;
        ending   = 1'b0;
        open     = (s_q.depth != '0);
        cyc_inc  = (&s_q.cyc) ? s_q.cyc : s_q.cyc + CYC_W'(1);
        abort_ev_o = 1'b0;
        if (!open) begin
            if (tx_begin) begin
                s_d.depth   = DEPTH_W'(1);
                s_d.cyc     = CYC_W'(1);
                s_d.kind    = tx_kind;
                s_d.restart = (tx_kind == KIND_EXPLICIT) ? begin_fallback_ip : begin_next_ip;
            end
        end else begin
            s_d.cyc = cyc_inc;
            if (sample_req) s_d.pend = 1'b1;
            if (tx_abort) begin
                s_d.depth  = '0;
                ending     = 1'b1;
                abort_ev_o = 1'b1;
            end else if (tx_commit) begin
                s_d.depth = s_q.depth - DEPTH_W'(1);
                ending    = (s_q.depth == DEPTH_W'(1));
            end else if (tx_begin && !(&s_q.depth)) begin
                s_d.depth = s_q.depth + DEPTH_W'(1);
            end
            if (ending) s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open_o       = open;
    assign pend_now_o   = s_q.pend | (open & sample_req);
    assign req_o        = s_q.pend;
    assign kind_o       = s_q.kind;
    assign restart_o    = s_q.restart;
    assign end_cycles_o = cyc_inc;
endmodule

// File: rtl/txab_counter.sv
`timescale 1ns/1ps
module txab_counter
    import txab_pkg::*;
#(
    parameter int CTR_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic             cnt_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic [CTR_W-1:0] cnt_wdata,
    input  logic             abort_ev,
    input  tx_kind_e         abort_kind,
    output logic [SEL_W-1:0] sel_o,
    output logic [CTR_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CTR_W-1:0] cnt;
        logic             armed;
    } ctr_t;

    ctr_t c_d, c_q;
    logic match, hit;

    always_comb begin
        c_d   = c_q;
        match = c_q.sel[16] && (c_q.sel[15:8] == UMASK_ABORT) &&
                ((abort_kind == KIND_EXPLICIT) ? (c_q.sel[7:0] == EV_EXPL_ABORT)
                                               : (c_q.sel[7:0] == EV_ELIDE_ABORT));
        hit   = abort_ev && match;
        ovf_o = hit && (&c_q.cnt) && c_q.armed;
        if (sel_we) c_d.sel = sel_wdata;
        if (cnt_we) begin
            c_d.cnt   = cnt_wdata;
            c_d.armed = 1'b1;
        end else if (hit) begin
            c_d.cnt = c_q.cnt + CTR_W'(1);
            if (ovf_o) c_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{sel: '0, cnt: '0, armed: 1'b1};
        else        c_q <= c_d;
    end

    assign sel_o = c_q.sel;
    assign cnt_o = c_q.cnt;
endmodule

// File: rtl/txab_record.sv
`timescale 1ns/1ps
module txab_record #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_req,
    input  logic [AW-1:0] eip,
    input  logic [AW-1:0] restart,
    input  logic [63:0]   info,
    input  logic          ready,
    input  logic          clr_lost,
    output logic          valid_o,
    output logic [AW-1:0] eip_o,
    output logic [AW-1:0] restart_o,
    output logic [63:0]   info_o,
    output logic          lost_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] eip;
        logic [AW-1:0] restart;
        logic [63:0]   info;
        logic          lost;
    } rec_t;

    rec_t r_d, r_q;
    logic slot_free;

    always_comb begin
        r_d       = r_q;
        slot_free = !r_q.valid || ready;
        if (clr_lost) r_d.lost = 1'b0;
        if (r_q.valid && ready) r_d.valid = 1'b0;
        if (load_req) begin
            if (slot_free) begin
                r_d.valid   = 1'b1;
                r_d.eip     = eip;
                r_d.restart = restart;
                r_d.info    = info;
            end else begin
                r_d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid_o   = r_q.valid;
    assign eip_o     = r_q.eip;
    assign restart_o = r_q.restart;
    assign info_o    = r_q.info;
    assign lost_o    = r_q.lost;
endmodule

// File: rtl/txab_sampler.sv
`timescale 1ns/1ps
module txab_sampler
    import txab_pkg::*;
#(
    parameter int AW      = 64,
    parameter int CTR_W   = 48,
    parameter int CYC_W   = 32,
    parameter int DEPTH_W = 4,
    parameter int NUM_CTR = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tx_begin,
    input  logic                                 tx_commit,
    input  logic                                 tx_abort,
    input  logic                                 tx_kind,
    input  logic [CAUSE_W-1:0]                   abort_cause,
    input  logic [AW-1:0]                        eventing_ip,
    input  logic [AW-1:0]                        begin_next_ip,
    input  logic [AW-1:0]                        begin_fallback_ip,
    input  logic                                 sample_req,
    output logic                                 abort_req,
    input  logic                                 reg_we,
    input  logic [$clog2(2*NUM_CTR+1)-1:0]       reg_addr,
    input  logic [txab_pkg::reg_w(CTR_W)-1:0]    reg_wdata,
    output logic [txab_pkg::reg_w(CTR_W)-1:0]    reg_rdata,
    output logic                                 rec_valid,
    input  logic                                 rec_ready,
    output logic [AW-1:0]                        rec_eventing_ip,
    output logic [AW-1:0]                        rec_restart_ip,
    output logic [63:0]                          rec_info
);
    localparam int RA_W    = $clog2(2*NUM_CTR+1);
    localparam int REG_W   = reg_w(CTR_W);
    localparam int STAT_AD = 2*NUM_CTR;

    logic             region_open, abort_ev, pend_now, lost;
    tx_kind_e         kind_q;
    logic [AW-1:0]    restart_q;
    logic [CYC_W-1:0] end_cycles;
    logic [NUM_CTR-1:0] ovf_vec;
    logic [SEL_W-1:0] sel_arr [NUM_CTR];
    logic [CTR_W-1:0] cnt_arr [NUM_CTR];
    logic             trigger;
    logic [63:0]      info_w;

    txab_region #(.AW(AW), .CYC_W(CYC_W), .DEPTH_W(DEPTH_W)) u_region (
        .clk(clk), .rst_n(rst_n),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
        .tx_kind(tx_kind_e'(tx_kind)),
        .begin_next_ip(begin_next_ip), .begin_fallback_ip(begin_fallback_ip),
        .sample_req(sample_req),
        .open_o(region_open), .abort_ev_o(abort_ev), .pend_now_o(pend_now),
        .req_o(abort_req), .kind_o(kind_q), .restart_o(restart_q),
        .end_cycles_o(end_cycles)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        txab_counter #(.CTR_W(CTR_W)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .sel_we(reg_we && (reg_addr == RA_W'(2*i))),
            .cnt_we(reg_we && (reg_addr == RA_W'(2*i+1))),
            .sel_wdata(reg_wdata[SEL_W-1:0]),
            .cnt_wdata(reg_wdata[CTR_W-1:0]),
            .abort_ev(abort_ev), .abort_kind(kind_q),
            .sel_o(sel_arr[i]), .cnt_o(cnt_arr[i]), .ovf_o(ovf_vec[i])
        );
    end

    assign trigger = abort_ev && (pend_now || (|ovf_vec));
    assign info_w  = pack_info(32'(end_cycles), kind_q, abort_cause);

    txab_record #(.AW(AW)) u_record (
        .clk(clk), .rst_n(rst_n),
        .load_req(trigger), .eip(eventing_ip), .restart(restart_q), .info(info_w),
        .ready(rec_ready), .clr_lost(reg_we && (reg_addr == RA_W'(STAT_AD))),
        .valid_o(rec_valid), .eip_o(rec_eventing_ip), .restart_o(rec_restart_ip),
        .info_o(rec_info), .lost_o(lost)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == RA_W'(2*i))   reg_rdata = REG_W'(sel_arr[i]);
            if (reg_addr == RA_W'(2*i+1)) reg_rdata = REG_W'(cnt_arr[i]);
        end
        if (reg_addr == RA_W'(STAT_AD)) reg_rdata = REG_W'(lost);
    end
endmodule

// File: rtl/txab_sampler_chk.sv
`timescale 1ns/1ps
module txab_sampler_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_abort,
    input logic          abort_req,
    input logic          region_open,
    input logic          rec_valid,
    input logic          rec_ready,
    input logic [AW-1:0] rec_eventing_ip,
    input logic [63:0]   rec_info
);
    p_req_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> region_open);

    p_emit_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_valid) |-> $past(tx_abort));

    p_hold_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_info) && $stable(rec_eventing_ip)));

    p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ($countones(rec_info[33:32]) == 1));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_info[63:40] == 24'h0));
endmodule

bind txab_sampler txab_sampler_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_abort(tx_abort), .abort_req(abort_req),
    .region_open(region_open), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_eventing_ip(rec_eventing_ip), .rec_info(rec_info)
);

// File: tb/txab_sampler_bench.sv
`timescale 1ns/1ps
module txab_sampler_bench;
    localparam int AW = 64, CTR_W = 8, CYC_W = 5, NUM_CTR = 2, REG_W = 17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_begin = 0, tx_commit = 0, tx_abort = 0, tx_kind = 0, sample_req = 0;
    logic [5:0] abort_cause = '0;
    logic [AW-1:0] eventing_ip = '0, begin_next_ip = '0, begin_fallback_ip = '0;
    logic abort_req, reg_we = 0, rec_valid, rec_ready = 0;
    logic [2:0] reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
    logic [AW-1:0] rec_eventing_ip, rec_restart_ip;
    logic [63:0] rec_info;
    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    txab_sampler #(.AW(AW), .CTR_W(CTR_W), .CYC_W(CYC_W), .NUM_CTR(NUM_CTR)) u_txab_sampler (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .tx_kind(tx_kind), .abort_cause(abort_cause),
        .eventing_ip(eventing_ip), .begin_next_ip(begin_next_ip),
        .begin_fallback_ip(begin_fallback_ip), .sample_req(sample_req),
        .abort_req(abort_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_eventing_ip(rec_eventing_ip),
        .rec_restart_ip(rec_restart_ip), .rec_info(rec_info)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_info(int cyc, logic kind, logic [5:0] cause);
        int c = (cyc > 31) ? 31 : cyc;
        return {24'h0, cause, kind, ~kind, 32'(c)};
    endfunction

    task automatic wr(logic [2:0] a, logic [REG_W-1:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [REG_W-1:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic tbegin(logic kind, logic [AW-1:0] nip, logic [AW-1:0] fip);
        tx_begin = 1; tx_kind = kind; begin_next_ip = nip; begin_fallback_ip = fip;
        @(negedge clk);
        tx_begin = 0; begin_next_ip = 64'hBAD0; begin_fallback_ip = 64'hBAD1; tx_kind = ~kind;
    endtask

    task automatic tabort(logic [5:0] cause, logic [AW-1:0] eip);
        tx_abort = 1; abort_cause = cause; eventing_ip = eip;
        @(negedge clk);
        tx_abort = 0; abort_cause = '0; eventing_ip = '0;
    endtask

    task automatic tcommit();
        tx_commit = 1; @(negedge clk); tx_commit = 0;
    endtask

    task automatic accept();
        rec_ready = 1; @(negedge clk); rec_ready = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [REG_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rec_valid", 64'(rec_valid), 0);
        chk("R1 abort_req", 64'(abort_req), 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk("R1 reg", 64'(v), 0);
        end

        // R2 programming
        wr(3'd0, 17'h104C8); wr(3'd2, 17'h104C9);
        wr(3'd1, 17'hFD);    wr(3'd3, 17'h00);
        rd(3'd0, v); chk("R2 sel0", 64'(v), 64'h104C8);
        rd(3'd2, v); chk("R2 sel1", 64'(v), 64'h104C9);

        // R2/R12 kind-matched counting, no record without trigger
        tbegin(0, 64'h10, 64'h20); tabort(6'h1, 64'h30);
        chk("R12 no record on plain abort", 64'(rec_valid), 0);
        rd(3'd1, v); chk("R2 ctr0 elide", 64'(v), 64'hFE);
        rd(3'd3, v); chk("R2 ctr1 untouched", 64'(v), 0);
        tbegin(1, 64'h10, 64'h20); tabort(6'h2, 64'h30);
        rd(3'd3, v); chk("R2 ctr1 explicit", 64'(v), 1);
        rd(3'd1, v); chk("R2 ctr0 untouched", 64'(v), 64'hFE);
        tbegin(1, 64'h10, 64'h20); tcommit();
        tbegin(0, 64'h10, 64'h20); tcommit();
        chk("R12 no record on commit", 64'(rec_valid), 0);
        rd(3'd1, v); chk("R2 commit not counted", 64'(v), 64'hFE);
        wr(3'd2, 17'h004C9);
        tbegin(1, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        rd(3'd3, v); chk("R2 disabled no count", 64'(v), 1);
        wr(3'd2, 17'h102C9);
        tbegin(1, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        rd(3'd3, v); chk("R2 wrong mask no count", 64'(v), 1);
        wr(3'd2, 17'h104C9);

        // R3/R6/R7/R9/R10 overflow record from nested lock-elision region
        tbegin(0, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        rd(3'd1, v); chk("R2 ctr0 at ones", 64'(v), 64'hFF);
        chk("R3 no record before wrap", 64'(rec_valid), 0);
        tbegin(0, 64'h1000, 64'h2000);
        @(negedge clk);
        tbegin(1, 64'h3000, 64'h4000);
        @(negedge clk);
        tcommit();
        @(negedge clk);
        chk("R4 no request without sample", 64'(abort_req), 0);
        tabort(6'b000101, 64'h5555);
        chk("R3 R5 record after wrap", 64'(rec_valid), 1);
        chk("R6 R7 R8 info", rec_info, exp_info(7, 0, 6'b000101));
        chk("R9 restart nested", rec_restart_ip, 64'h1000);
        chk("R10 eventing ip", rec_eventing_ip, 64'h5555);
        rd(3'd1, v); chk("R3 ctr0 wrapped", 64'(v), 0);
        @(negedge clk);
        chk("R11 held without ready", 64'(rec_valid), 1);
        accept();
        chk("R11 accepted", 64'(rec_valid), 0);

        // R3 re-arm rule on ctr1
        wr(3'd3, 17'hFF);
        tbegin(1, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        chk("R3 explicit wrap record", 64'(rec_valid), 1);
        chk("R9 restart explicit", rec_restart_ip, 64'h20);
        accept();
        for (int n = 0; n < 256; n++) begin
            tbegin(1, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        end
        chk("R3 disarmed wrap no record", 64'(rec_valid), 0);
        rd(3'd3, v); chk("R3 ctr1 wrapped again", 64'(v), 0);
        wr(3'd3, 17'hFF);
        tbegin(1, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        chk("R3 re-armed record", 64'(rec_valid), 1);
        accept();

        // R4/R5/R6/R7/R8/R9 sweep of region length, kind and cause
        for (int len = 1; len <= 34; len++) begin
            logic k = len[0];
            logic [5:0] cz = 6'(len) ^ 6'h2A;
            tbegin(k, 64'(len * 256), 64'(len * 256 + 64));
            sample_req = 1; @(negedge clk); sample_req = 0;
            chk("R4 abort_req raised", 64'(abort_req), 1);
            chk("R5 no early record", 64'(rec_valid), 0);
            repeat (len - 1) @(negedge clk);
            tabort(cz, 64'(32768 + len));
            chk("R5 record after abort", 64'(rec_valid), 1);
            chk("R4 request dropped", 64'(abort_req), 0);
            chk("R6 R7 R8 sweep info", rec_info, exp_info(len + 2, k, cz));
            chk("R9 sweep restart", rec_restart_ip, k ? 64'(len * 256 + 64) : 64'(len * 256));
            chk("R10 sweep eip", rec_eventing_ip, 64'(32768 + len));
            accept();
        end

        // R4 request outside region ignored
        sample_req = 1; @(negedge clk); sample_req = 0;
        chk("R4 outside no request", 64'(abort_req), 0);
        tbegin(0, 64'h10, 64'h20); tabort(6'h0, 64'h30);
        chk("R4 outside no record", 64'(rec_valid), 0);

        // R12 commit with pending sample
        tbegin(1, 64'h10, 64'h20);
        sample_req = 1; @(negedge clk); sample_req = 0;
        chk("R4 request in region", 64'(abort_req), 1);
        tcommit();
        chk("R12 commit drops request", 64'(abort_req), 0);
        chk("R12 commit no record", 64'(rec_valid), 0);

        // R11 second trigger dropped, lost flag
        tbegin(0, 64'hA0, 64'hB0);
        sample_req = 1; @(negedge clk); sample_req = 0;
        tabort(6'h8, 64'hAAAA);
        tbegin(1, 64'hC0, 64'hD0);
        sample_req = 1; @(negedge clk); sample_req = 0;
        tabort(6'h10, 64'hBBBB);
        chk("R11 first record kept", rec_eventing_ip, 64'hAAAA);
        chk("R11 first info kept", rec_info, exp_info(3, 0, 6'h8));
        rd(3'd4, v); chk("R11 lost set", 64'(v), 1);
        wr(3'd4, 17'h0);
        rd(3'd4, v); chk("R11 lost cleared", 64'(v), 0);
        accept();
        chk("R11 released", 64'(rec_valid), 0);

        summary();
    end
endmodule